// File: doc/BRIEF.md
# Integer Execute and Writeback Unit

This block accepts one 32-bit instruction word per clock from a compact integer subset. It decodes the word, reads its source operands from an internal register file of 32 entries, computes the result on a single shared execute path, and commits that result to the destination entry on the rising clock edge while the instruction-valid strobe is high. The subset covers register-register arithmetic and logic, shifts by a constant amount, and immediate forms with sign or zero extension. Memory access and control transfer are not part of the subset.

Each accepted instruction is reported one cycle later on a registered writeback port that gives the destination index and the value. A word whose opcode or function code falls outside the subset writes nothing and raises an illegal-instruction pulse in the same reporting cycle. Two debug read ports give combinational access to any register, so the file can be inspected through the block's normal interface.

Top module: `iexu_top`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero and `wb_en` and `illegal` are low.
- R2: With opcode 0x00, func 0x21 writes R[rs]+R[rt] and func 0x23 writes R[rs]-R[rt] to R[rd], both modulo 2^32 with no overflow signalled. The fields are opcode bits 31:26, rs 25:21, rt 20:16, rd 15:11, shamt 10:6 and func 5:0.
- R3: With opcode 0x00, func 0x25 writes R[rs]|R[rt], func 0x26 writes R[rs]^R[rt] and func 0x27 writes ~(R[rs]|R[rt]) to R[rd].
- R4: With opcode 0x00, func 0x00 shifts R[rt] left by shamt, func 0x02 shifts it right filling with zeros, and func 0x03 shifts it right filling with bit 31; the result goes to R[rd].
- R5: Opcode 0x09 writes R[rs] plus the sign-extended 16-bit immediate (bits 15:0) to the register named by bits 20:16, with no overflow signalled.
- R6: Opcode 0x0C writes R[rs] AND the zero-extended immediate, and opcode 0x0D writes R[rs] OR the zero-extended immediate, to the register named by bits 20:16.
- R7: Opcode 0x0F writes the immediate into bits 31:16 of the register named by bits 20:16 and clears bits 15:0; the rs field has no effect.
- R8: Register 0 always reads zero; a write aimed at it is discarded.
- R9: The register file changes only on a rising clock edge with `instr_valid` high; with it low no register changes and `wb_en` stays low.
- R10: An opcode or R-type func outside the subset raises `illegal` for exactly one cycle after the edge that sampled it, writes no register, and keeps `wb_en` low.
- R11: One cycle after a legal instruction is accepted, `wb_en` is high for one cycle with `wb_idx` equal to the destination field and `wb_value` equal to the computed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | The instruction word is to be executed on this edge |
| instr | input | 32 | Instruction word |
| dbg_idx_a | input | 5 | Debug read index, port A |
| dbg_idx_b | input | 5 | Debug read index, port B |
| dbg_val_a | output | DATA_W | Register content at `dbg_idx_a` |
| dbg_val_b | output | DATA_W | Register content at `dbg_idx_b` |
| wb_en | output | 1 | A legal instruction was retired on the previous edge |
| wb_idx | output | 5 | Destination index of the retired instruction |
| wb_value | output | DATA_W | Result of the retired instruction |
| illegal | output | 1 | An undefined instruction was presented on the previous edge |

## Verification
Operands are chosen so that each operation gives a result no neighbouring operation could produce: sums that wrap at bit 31 and at 2^32 separate modulo arithmetic from saturation, and a source with bit 31 and a low bit set separates logical from arithmetic right shift and shows bits leaving either end. Immediates with bit 15 set distinguish sign extension (add-immediate) from zero extension (AND/OR-immediate), and a nonzero rs field under the upper-immediate form shows that the shared path ignores it. Writes to register 0, words presented with the strobe low, and undefined opcode and func codes are each followed by debug reads of the register they could have changed.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

   localparam int unsigned INSN_W  = 32;
   localparam int unsigned FIELD_W = 5;

   localparam logic [5:0] OPC_REGOP = 6'h00;
   localparam logic [5:0] OPC_ADDI  = 6'h09;
   localparam logic [5:0] OPC_ANDI  = 6'h0C;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_UPPER = 6'h0F;

   localparam logic [5:0] FN_SHL  = 6'h00;
   localparam logic [5:0] FN_SHRL = 6'h02;
   localparam logic [5:0] FN_SHRA = 6'h03;
   localparam logic [5:0] FN_ADD  = 6'h21;
   localparam logic [5:0] FN_SUB  = 6'h23;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_XOR  = 6'h26;
   localparam logic [5:0] FN_NOR  = 6'h27;

   typedef enum logic [3:0] {
      XOP_ADD, XOP_SUB, XOP_AND, XOP_OR, XOP_XOR, XOP_NOR,
      XOP_SHL, XOP_SHRL, XOP_SHRA
   } xop_e;

   typedef enum logic [1:0] { ASRC_RS, ASRC_RT, ASRC_IMM } asrc_e;
   typedef enum logic [1:0] { BSRC_REG, BSRC_SEXT, BSRC_ZEXT } bsrc_e;

   typedef struct packed {
      logic               legal;
      xop_e               op;
      asrc_e              a_src;
      bsrc_e              b_src;
      logic               sh_half;
      logic [FIELD_W-1:0] dst;
   } dec_t;

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
   import iexu_pkg::*;
(
   input  logic [INSN_W-1:0]  instr,
   output dec_t               dec,
   output logic [FIELD_W-1:0] src_s,
   output logic [FIELD_W-1:0] src_t,
   output logic [FIELD_W-1:0] sh_field,
   output logic [15:0]        imm
);

   logic [5:0]         opc;
   logic [5:0]         fn;
   logic [FIELD_W-1:0] dst_r;

   assign opc      = instr[31:26];
   assign src_s    = instr[25:21];
   assign src_t    = instr[20:16];
   assign dst_r    = instr[15:11];
   assign sh_field = instr[10:6];
   assign fn       = instr[5:0];
   assign imm      = instr[15:0];

   always_comb begin
      dec         = '0;
      dec.op      = XOP_ADD;
      dec.a_src   = ASRC_RS;
      dec.b_src   = BSRC_REG;
      dec.dst     = src_t;
      case (opc)
         OPC_REGOP: begin
            dec.dst   = dst_r;
            dec.legal = 1'b1;
            case (fn)
               FN_ADD:  dec.op = XOP_ADD;
               FN_SUB:  dec.op = XOP_SUB;
               FN_OR:   dec.op = XOP_OR;
               FN_XOR:  dec.op = XOP_XOR;
               FN_NOR:  dec.op = XOP_NOR;
               FN_SHL:  begin dec.op = XOP_SHL;  dec.a_src = ASRC_RT; end
               FN_SHRL: begin dec.op = XOP_SHRL; dec.a_src = ASRC_RT; end
               FN_SHRA: begin dec.op = XOP_SHRA; dec.a_src = ASRC_RT; end
               default: dec.legal = 1'b0;
            endcase
         end
         OPC_ADDI: begin
            dec.legal = 1'b1;
            dec.op    = XOP_ADD;
            dec.b_src = BSRC_SEXT;
         end
         OPC_ANDI: begin
            dec.legal = 1'b1;
            dec.op    = XOP_AND;
            dec.b_src = BSRC_ZEXT;
         end
         OPC_ORI: begin
            dec.legal = 1'b1;
            dec.op    = XOP_OR;
            dec.b_src = BSRC_ZEXT;
         end
         OPC_UPPER: begin
            dec.legal   = 1'b1;
            dec.op      = XOP_SHL;
            dec.a_src   = ASRC_IMM;
            dec.sh_half = 1'b1;
         end
         default: dec.legal = 1'b0;
      endcase
   end

   // R4/R7: only shift forms may draw operand A from outside rs
   always_comb begin
      if (dec.legal && dec.a_src != ASRC_RS)
         assert_shift_src_R4: assert (dec.op == XOP_SHL || dec.op == XOP_SHRL || dec.op == XOP_SHRA);
   end

endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
   import iexu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned SH_W  = $clog2(DATA_W)
) (
   input  xop_e              op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] res
);

   always_comb begin
      case (op)
         XOP_ADD:  res = opa + opb;
         XOP_SUB:  res = opa - opb;
         XOP_AND:  res = opa & opb;
         XOP_OR:   res = opa | opb;
         XOP_XOR:  res = opa ^ opb;
         XOP_NOR:  res = ~(opa | opb);
         XOP_SHL:  res = opa << amt;
         XOP_SHRL: res = opa >> amt;
         XOP_SHRA: res = DATA_W'($signed(opa) >>> amt);
         default:  res = '0;
      endcase
   end

   // R4: right shifts fill the top bit with zero or with the sign
   always_comb begin
      if (op == XOP_SHRL && amt != '0)
         assert_shrl_fill_R4: assert (res[DATA_W-1] == 1'b0);
      if (op == XOP_SHRA)
         assert_shra_fill_R4: assert (res[DATA_W-1] == opa[DATA_W-1]);
   end

endmodule

// File: rtl/iexu_regfile.sv
module iexu_regfile #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned NUM_RD   = 4,
   localparam int unsigned AW      = $clog2(DEPTH)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [AW-1:0]                  waddr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [NUM_RD-1:0][AW-1:0]      raddr,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("iexu_regfile: DEPTH must be a power of two of at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && waddr != '0) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
   end

   // R8: entry zero never holds anything but zero
   assert_zero_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem[0] == '0);

   // R9: an entry not addressed by a write keeps its content
   for (genvar e = 0; e < DEPTH; e++) begin : g_hold
      assert_hold_unwritten_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && waddr == AW'(e)) |=> mem[e] == $past(mem[e]));
   end

endmodule

// File: rtl/iexu_top.sv
module iexu_top
   import iexu_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic [4:0]        dbg_idx_a,
   input  logic [4:0]        dbg_idx_b,
   output logic [DATA_W-1:0] dbg_val_a,
   output logic [DATA_W-1:0] dbg_val_b,
   output logic              wb_en,
   output logic [4:0]        wb_idx,
   output logic [DATA_W-1:0] wb_value,
   output logic              illegal
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);
   localparam int unsigned SH_W  = $clog2(DATA_W);
   localparam int unsigned EXT_W = DATA_W - 16;

   if (NUM_REGS != (1 << FIELD_W)) begin : g_bad_regs
      $error("iexu_top: NUM_REGS must match the 5-bit register fields");
   end
   if (DATA_W != INSN_W) begin : g_bad_width
      $error("iexu_top: DATA_W must equal the 32-bit word format");
   end

   dec_t               dec;
   logic [FIELD_W-1:0] src_s, src_t, sh_field;
   logic [15:0]        imm;

   iexu_decode u_dec (
      .instr    (instr),
      .dec      (dec),
      .src_s    (src_s),
      .src_t    (src_t),
      .sh_field (sh_field),
      .imm      (imm)
   );

   logic [3:0][IDX_W-1:0]  rf_raddr;
   logic [3:0][DATA_W-1:0] rf_rdata;
   logic                   rf_we;
   logic [DATA_W-1:0]      result;

   assign rf_raddr[0] = src_s;
   assign rf_raddr[1] = src_t;
   assign rf_raddr[2] = dbg_idx_a;
   assign rf_raddr[3] = dbg_idx_b;
   assign rf_we       = instr_valid && dec.legal;

   iexu_regfile #(.DATA_W(DATA_W), .DEPTH(NUM_REGS), .NUM_RD(4)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (dec.dst),
      .wdata (result),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

   assign dbg_val_a = rf_rdata[2];
   assign dbg_val_b = rf_rdata[3];

   // shared operand selection for register, shift and immediate forms
   logic [DATA_W-1:0] imm_s, imm_z, opa, opb;
   logic [SH_W-1:0]   amt;

   assign imm_s = {{EXT_W{imm[15]}}, imm};
   assign imm_z = {{EXT_W{1'b0}}, imm};

   always_comb begin
      case (dec.a_src)
         ASRC_RT:  opa = rf_rdata[1];
         ASRC_IMM: opa = imm_z;
         default:  opa = rf_rdata[0];
      endcase
      case (dec.b_src)
         BSRC_SEXT: opb = imm_s;
         BSRC_ZEXT: opb = imm_z;
         default:   opb = rf_rdata[1];
      endcase
      amt = dec.sh_half ? SH_W'(16) : SH_W'(sh_field);
   end

   iexu_alu #(.DATA_W(DATA_W)) u_alu (
      .op  (dec.op),
      .opa (opa),
      .opb (opb),
      .amt (amt),
      .res (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en    <= 1'b0;
         wb_idx   <= '0;
         wb_value <= '0;
         illegal  <= 1'b0;
      end else begin
         wb_en   <= rf_we;
         illegal <= instr_valid && !dec.legal;
         if (rf_we) begin
            wb_idx   <= dec.dst;
            wb_value <= result;
         end
      end
   end

   // R10: an illegal report never coincides with a writeback
   assert_illegal_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !wb_en);

   // R9: any report needs a strobe on the edge before
   assert_report_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en || illegal) |-> $past(instr_valid));

   // R7: upper-immediate results have a clear low half
   assert_upper_low_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[31:26] == OPC_UPPER) |=> wb_value[15:0] == '0);

   // R11: a write to a nonzero index shows the reported value on debug port A
   assert_wb_reported_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && dec.dst != '0 && dbg_idx_a == dec.dst) |=>
      (wb_en && ($stable(dbg_idx_a) -> dbg_val_a == wb_value)));

endmodule

// File: tb/iexu_top_bench.sv
module iexu_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [4:0]  dbg_idx_a = '0;
   logic [4:0]  dbg_idx_b = '0;
   logic [31:0] dbg_val_a, dbg_val_b, wb_value;
   logic        wb_en, illegal;
   logic [4:0]  wb_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   iexu_top u_iexu_top (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .dbg_idx_a(dbg_idx_a), .dbg_idx_b(dbg_idx_b),
      .dbg_val_a(dbg_val_a), .dbg_val_b(dbg_val_b),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_value(wb_value), .illegal(illegal)
   );

   function automatic logic [31:0] rform(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [4:0] sh,
                                         input logic [5:0] fn);
      return {6'h00, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] im);
      return {op, rs, rt, im};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic rd_reg(input logic [4:0] idx, output logic [31:0] val);
      dbg_idx_a = idx;
      #1;
      val = dbg_val_a;
   endtask

   // drive a word with the strobe for one edge; return at the next falling edge
   task automatic issue(input logic [31:0] w);
      @(negedge clk);
      instr = w;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   task automatic load(input logic [4:0] r, input logic [31:0] v);
      issue(iform(6'h0F, 5'd0, r, v[31:16]));
      issue(iform(6'h0D, r, r, v[15:0]));
   endtask

   task automatic t_reset();
      logic [31:0] v;
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
         rd_reg(5'(i), v);
         if (v !== 32'h0) bad++;
      end
      chk("R1 registers cleared", 32'(bad), 32'd0);
      chk("R1 wb_en low", {31'd0, wb_en}, 32'd0);
      chk("R1 illegal low", {31'd0, illegal}, 32'd0);
   endtask

   task automatic t_addsub();
      logic [31:0] v;
      load(5'd1, 32'h7FFF_FFFF);
      load(5'd2, 32'h0000_0001);
      issue(rform(5'd1, 5'd2, 5'd3, 5'd0, 6'h21));
      chk("R2 add wb_value", wb_value, 32'h8000_0000);
      chk("R11 wb_en", {31'd0, wb_en}, 32'd1);
      chk("R11 wb_idx", {27'd0, wb_idx}, 32'd3);
      rd_reg(5'd3, v);
      chk("R2 add stored", v, 32'h8000_0000);
      issue(rform(5'd2, 5'd1, 5'd4, 5'd0, 6'h23));
      chk("R2 sub wrap", wb_value, 32'h8000_0002);
      load(5'd5, 32'hFFFF_FFFF);
      issue(rform(5'd5, 5'd2, 5'd6, 5'd0, 6'h21));
      chk("R2 add wraps to zero", wb_value, 32'h0);
      @(negedge clk);
      chk("R11 wb_en single cycle", {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_logic();
      load(5'd1, 32'hF0F0_1234);
      load(5'd2, 32'h0FF0_00FF);
      issue(rform(5'd1, 5'd2, 5'd7, 5'd0, 6'h25));
      chk("R3 or", wb_value, 32'hFFF0_12FF);
      issue(rform(5'd1, 5'd2, 5'd8, 5'd0, 6'h26));
      chk("R3 xor", wb_value, 32'hFF00_12CB);
      issue(rform(5'd1, 5'd2, 5'd9, 5'd0, 6'h27));
      chk("R3 nor", wb_value, 32'h000F_ED00);
   endtask

   task automatic t_shift();
      load(5'd10, 32'h8000_0010);
      issue(rform(5'd0, 5'd10, 5'd11, 5'd4, 6'h00));
      chk("R4 shift left", wb_value, 32'h0000_0100);
      issue(rform(5'd0, 5'd10, 5'd11, 5'd4, 6'h02));
      chk("R4 shift right logical", wb_value, 32'h0800_0001);
      issue(rform(5'd0, 5'd10, 5'd11, 5'd4, 6'h03));
      chk("R4 shift right arithmetic", wb_value, 32'hF800_0001);
      issue(rform(5'd0, 5'd10, 5'd11, 5'd0, 6'h03));
      chk("R4 shift by zero", wb_value, 32'h8000_0010);
      issue(rform(5'd0, 5'd10, 5'd11, 5'd31, 6'h03));
      chk("R4 arithmetic by 31", wb_value, 32'hFFFF_FFFF);
      issue(rform(5'd0, 5'd10, 5'd11, 5'd31, 6'h02));
      chk("R4 logical by 31", wb_value, 32'h0000_0001);
   endtask

   task automatic t_addi();
      logic [31:0] v;
      load(5'd12, 32'h0000_0010);
      issue(iform(6'h09, 5'd12, 5'd13, 16'hFFFF));
      chk("R5 negative immediate", wb_value, 32'h0000_000F);
      chk("R5 destination field", {27'd0, wb_idx}, 32'd13);
      issue(iform(6'h09, 5'd0, 5'd14, 16'h8000));
      rd_reg(5'd14, v);
      chk("R5 sign extension", v, 32'hFFFF_8000);
   endtask

   task automatic t_logic_imm();
      load(5'd15, 32'hFFFF_FFFF);
      issue(iform(6'h0C, 5'd15, 5'd16, 16'h8001));
      chk("R6 and zero extended", wb_value, 32'h0000_8001);
      load(5'd17, 32'h1234_0000);
      issue(iform(6'h0D, 5'd17, 5'd18, 16'h8000));
      chk("R6 or zero extended", wb_value, 32'h1234_8000);
   endtask

   task automatic t_upper();
      load(5'd3, 32'h0000_FFFF);
      issue(iform(6'h0F, 5'd3, 5'd19, 16'hABCD));
      chk("R7 upper immediate", wb_value, 32'hABCD_0000);
      chk("R7 destination field", {27'd0, wb_idx}, 32'd19);
   endtask

   task automatic t_zero_reg();
      logic [31:0] v;
      issue(iform(6'h09, 5'd0, 5'd0, 16'h0005));
      rd_reg(5'd0, v);
      chk("R8 write to r0 dropped", v, 32'h0);
      issue(rform(5'd0, 5'd0, 5'd20, 5'd0, 6'h21));
      chk("R8 r0 operand zero", wb_value, 32'h0);
   endtask

   task automatic t_no_valid();
      logic [31:0] v;
      load(5'd21, 32'h0000_0777);
      @(negedge clk);
      instr = iform(6'h09, 5'd0, 5'd21, 16'h0055);
      instr_valid = 1'b0;
      @(negedge clk);
      chk("R9 no wb without strobe", {31'd0, wb_en}, 32'd0);
      rd_reg(5'd21, v);
      chk("R9 register unchanged", v, 32'h0000_0777);
   endtask

   task automatic t_illegal();
      logic [31:0] v;
      load(5'd22, 32'h0000_1111);
      issue(iform(6'h23, 5'd0, 5'd22, 16'h0004));
      chk("R10 illegal opcode flag", {31'd0, illegal}, 32'd1);
      chk("R10 no wb on illegal", {31'd0, wb_en}, 32'd0);
      rd_reg(5'd22, v);
      chk("R10 destination unchanged", v, 32'h0000_1111);
      @(negedge clk);
      chk("R10 flag one cycle", {31'd0, illegal}, 32'd0);
      issue(rform(5'd22, 5'd22, 5'd22, 5'd0, 6'h20));
      chk("R10 illegal func flag", {31'd0, illegal}, 32'd1);
      rd_reg(5'd22, v);
      chk("R10 func destination unchanged", v, 32'h0000_1111);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addsub();
      t_logic();
      t_shift();
      t_addi();
      t_logic_imm();
      t_upper();
      t_zero_reg();
      t_no_valid();
      t_illegal();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule